// File: doc/BRIEF.md
# Ping-pong OUT Endpoint Controller

This block looks after a single bulk or interrupt OUT endpoint backed by two receive buffers that are filled turn about. A token-level serial engine tells it when an OUT data packet starts, hands it the payload bytes one at a time, and marks the end of the packet together with the result of the CRC check. The controller picks the buffer that takes the payload and stores the bytes in an internal two-port array. At the end of the packet it answers with ACK, NAK or STALL, or stays silent.

Firmware sees a done flag and a byte count for each buffer, a sticky flag that records a sent STALL, and a force-stall control. It reads buffer contents through a synchronous read port and frees a buffer by clearing that buffer's done flag. A single interrupt line stays high while any of the three flags is set. Because the host can fill the second buffer while firmware is still draining the first, both done flags can be set at once. Firmware then clears them in fill order, buffer 0 before buffer 1, alternating after that.

Top module: `dual_bank_out_ep`

## Requirements
- R1: While `rst` is high and after it falls, both done flags, `stall_sent`, `force_stall`, `hs_valid`, `irq` and `next_bank` are 0.
- R2: Accepted (ACKed) packets go to bank 0, then bank 1, then bank 0, and so on. `next_bank` toggles only in the cycle an ACK is issued.
- R3: A reply appears on `hs_valid` with `hs_code` exactly one cycle after the `rx_end` cycle. Codes are 01 = ACK, 10 = NAK, 11 = STALL. On ACK, the target bank's done flag and byte count are updated in the same cycle as `hs_valid`.
- R4: If the target bank's done flag is set when `rx_start` is seen, the packet gets NAK. Nothing is written into the bank, and neither the pointer nor the count changes.
- R5: A payload of more than 64 bytes gets NAK. It sets no flag and does not move the pointer.
- R6: If `rx_crc_ok` is low during `rx_end`, no handshake is given. No flag is set and the pointer does not move.
- R7: A pulse on `fw_stall_set` makes `force_stall` 1 and a pulse on `fw_stall_clr` makes it 0; set wins if both pulse together. While `force_stall` is 1, every packet with a good CRC gets STALL and is not flagged.
- R8: `stall_sent` rises in the cycle a STALL is issued. It stays set through later packets until `fw_clr_stallsent` pulses.
- R9: `irq` is high exactly when `rx_done_bk0`, `rx_done_bk1` or `stall_sent` is high.
- R10: `fw_clr_bk0` and `fw_clr_bk1` clear their own flags only. Both flags can be set at once.
- R11: A read of bank `fw_rd_bank` at byte `fw_rd_addr` returns that stored payload byte on `fw_rd_data` one cycle later.
- R12: Each bank's byte count holds the length of its last accepted payload, from 0 to 64. A zero-length packet is accepted with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | An OUT data packet begins |
| rx_valid | input | 1 | Payload byte valid on rx_data |
| rx_data | input | 8 | Payload byte |
| rx_end | input | 1 | Packet finished (cycle after last byte) |
| rx_crc_ok | input | 1 | CRC result, sampled with rx_end |
| hs_valid | output | 1 | Handshake reply valid (one cycle) |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| fw_stall_set | input | 1 | Firmware pulse: start forcing STALL |
| fw_stall_clr | input | 1 | Firmware pulse: stop forcing STALL |
| fw_clr_bk0 | input | 1 | Firmware pulse: clear bank 0 done flag |
| fw_clr_bk1 | input | 1 | Firmware pulse: clear bank 1 done flag |
| fw_clr_stallsent | input | 1 | Firmware pulse: clear stall_sent |
| fw_rd_bank | input | 1 | Bank selected for reading |
| fw_rd_addr | input | 6 | Byte index for reading |
| fw_rd_data | output | 8 | Read data, one cycle latency |
| bk0_count | output | 11 | Byte count of bank 0 |
| bk1_count | output | 11 | Byte count of bank 1 |
| rx_done_bk0 | output | 1 | Bank 0 holds an unread packet |
| rx_done_bk1 | output | 1 | Bank 1 holds an unread packet |
| stall_sent | output | 1 | A STALL has been sent |
| force_stall | output | 1 | STALL forcing is active |
| next_bank | output | 1 | Bank the next accepted packet goes to |
| irq | output | 1 | Endpoint interrupt |

## Verification
A bank pointer that slips out of step with the flags shows up at the ports in the cycle after the next `rx_end`. The symptom is the wrong handshake code or a done flag raised on the wrong bank, and `next_bank` disagrees at once. A lost or stuck overflow or store decision turns an ACK into a NAK, or the reverse, in that same reply cycle. A stale write shows as a bad byte one cycle after firmware reads the location. Because every output is compared against an independent reference on every clock, a corrupted flag or count is caught within one cycle of being observable.

// File: rtl/dbo_pkg.sv
package dbo_pkg;

    localparam int DATA_W = 8;
    localparam int NBANK  = 2;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef struct packed {
        logic active;   // inside a packet
        logic store;    // payload is being kept
        logic ovf;      // too many bytes seen
    } pkt_st_t;

    // Reply chosen at the end of a packet
    function automatic hs_e pick_reply(logic crc_ok, logic force_on,
                                       logic store, logic ovf);
        hs_e r;
        if (!crc_ok)              r = HS_NONE;
        else if (force_on)        r = HS_STALL;
        else if (!store || ovf)   r = HS_NAK;
        else                      r = HS_ACK;
        return r;
    endfunction

endpackage

// File: rtl/dbo_dpram.sv
module dbo_dpram #(
    parameter int DW    = 8,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/dbo_rx_track.sv
module dbo_rx_track
    import dbo_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = 11,
    parameter int AW      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_ok,
    input  logic              cur_bank,
    input  logic              cur_busy,
    input  logic              force_on,
    output logic              wr_en,
    output logic [AW:0]       wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output hs_e               done_reply,
    output logic [CNT_W-1:0]  done_count
);
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_PKT);

    pkt_st_t          st_q;
    logic [CNT_W-1:0] idx_q;
    logic             room;
    logic             byte_in;

    assign room    = (idx_q < MAXC);
    assign byte_in = st_q.active && !rx_end && rx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            idx_q <= '0;
        end else if (rx_start && !st_q.active) begin
            st_q.active <= 1'b1;
            st_q.store  <= !force_on && !cur_busy;
            st_q.ovf    <= 1'b0;
            idx_q       <= '0;
        end else if (st_q.active) begin
            if (rx_end) begin
                st_q.active <= 1'b0;
            end else if (rx_valid) begin
                if (room) idx_q    <= idx_q + 1'b1;
                else      st_q.ovf <= 1'b1;
            end
        end
    end

    assign wr_en      = byte_in && st_q.store && room;
    assign wr_addr    = {cur_bank, idx_q[AW-1:0]};
    assign wr_data    = rx_data;
    assign done       = st_q.active && rx_end;
    assign done_reply = pick_reply(rx_crc_ok, force_on, st_q.store, st_q.ovf);
    assign done_count = idx_q;
endmodule

// File: rtl/dbo_bank_slot.sv
module dbo_bank_slot #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill,
    input  logic             release_i,
    input  logic [CNT_W-1:0] count_in,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full  <= 1'b0;
            count <= '0;
        end else if (fill) begin
            full  <= 1'b1;
            count <= count_in;
        end else if (release_i) begin
            full  <= 1'b0;
        end
    end
endmodule

// File: rtl/dbo_ep_state.sv
module dbo_ep_state
    import dbo_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  hs_e              done_reply,
    input  logic [CNT_W-1:0] done_count,
    input  logic             fw_stall_set,
    input  logic             fw_stall_clr,
    input  logic             fw_clr_stallsent,
    input  logic [NBANK-1:0] fw_clr,
    output logic [NBANK-1:0] full,
    output logic [CNT_W-1:0] count [NBANK],
    output logic             ptr,
    output logic             stall_q,
    output logic             force_q,
    output logic             hs_valid_q,
    output hs_e              hs_code_q
);
    logic ack_now;
    logic stall_now;

    assign ack_now   = done && (done_reply == HS_ACK);
    assign stall_now = done && (done_reply == HS_STALL);

    for (genvar b = 0; b < NBANK; b++) begin : g_slot
        dbo_bank_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .fill     (ack_now && (ptr == b[0])),
            .release_i(fw_clr[b]),
            .count_in (done_count),
            .full     (full[b]),
            .count    (count[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= 1'b0;
            stall_q    <= 1'b0;
            force_q    <= 1'b0;
            hs_valid_q <= 1'b0;
            hs_code_q  <= HS_NONE;
        end else begin
            hs_valid_q <= done && (done_reply != HS_NONE);
            hs_code_q  <= done ? done_reply : HS_NONE;
            if (ack_now) ptr <= ~ptr;
            if (stall_now)             stall_q <= 1'b1;
            else if (fw_clr_stallsent) stall_q <= 1'b0;
            if (fw_stall_set)          force_q <= 1'b1;
            else if (fw_stall_clr)     force_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_bank_out_ep.sv
module dual_bank_out_ep
    import dbo_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = 11,
    parameter int AW      = $clog2(MAX_PKT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_end,
    input  logic             rx_crc_ok,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    input  logic             fw_stall_set,
    input  logic             fw_stall_clr,
    input  logic             fw_clr_bk0,
    input  logic             fw_clr_bk1,
    input  logic             fw_clr_stallsent,
    input  logic             fw_rd_bank,
    input  logic [AW-1:0]    fw_rd_addr,
    output logic [7:0]       fw_rd_data,
    output logic [CNT_W-1:0] bk0_count,
    output logic [CNT_W-1:0] bk1_count,
    output logic             rx_done_bk0,
    output logic             rx_done_bk1,
    output logic             stall_sent,
    output logic             force_stall,
    output logic             next_bank,
    output logic             irq
);
    logic              wr_en;
    logic [AW:0]       wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              done;
    hs_e               done_reply;
    logic [CNT_W-1:0]  done_count;
    logic [NBANK-1:0]  full;
    logic [CNT_W-1:0]  count [NBANK];
    logic              ptr;
    logic              stall_q;
    logic              force_q;
    logic              hsv_q;
    hs_e               hsc_q;

    dbo_rx_track #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W), .AW(AW)) u_track (
        .clk        (clk),
        .rst        (rst),
        .rx_start   (rx_start),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_end     (rx_end),
        .rx_crc_ok  (rx_crc_ok),
        .cur_bank   (ptr),
        .cur_busy   (full[ptr]),
        .force_on   (force_q),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done       (done),
        .done_reply (done_reply),
        .done_count (done_count)
    );

    dbo_ep_state #(.CNT_W(CNT_W)) u_state (
        .clk              (clk),
        .rst              (rst),
        .done             (done),
        .done_reply       (done_reply),
        .done_count       (done_count),
        .fw_stall_set     (fw_stall_set),
        .fw_stall_clr     (fw_stall_clr),
        .fw_clr_stallsent (fw_clr_stallsent),
        .fw_clr           ({fw_clr_bk1, fw_clr_bk0}),
        .full             (full),
        .count            (count),
        .ptr              (ptr),
        .stall_q          (stall_q),
        .force_q          (force_q),
        .hs_valid_q       (hsv_q),
        .hs_code_q        (hsc_q)
    );

    dbo_dpram #(.DW(DATA_W), .AW(AW + 1)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr ({fw_rd_bank, fw_rd_addr}),
        .rdata (fw_rd_data)
    );

    assign hs_valid    = hsv_q;
    assign hs_code     = hsc_q;
    assign bk0_count   = count[0];
    assign bk1_count   = count[1];
    assign rx_done_bk0 = full[0];
    assign rx_done_bk1 = full[1];
    assign stall_sent  = stall_q;
    assign force_stall = force_q;
    assign next_bank   = ptr;
    assign irq         = |full || stall_q;
endmodule

// File: rtl/dbo_ep_checker.sv
module dbo_ep_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_end,
    input logic       rx_crc_ok,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       rx_done_bk0,
    input logic       rx_done_bk1,
    input logic       stall_sent,
    input logic       next_bank
);
    AST_ACK_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'b01) |-> ($rose(rx_done_bk0) || $rose(rx_done_bk1))); // R3
    AST_REPLY_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(rx_end)); // R3
    AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(rx_end && !rx_crc_ok) |-> !hs_valid); // R6
    AST_PTR_MOVES_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        !$stable(next_bank) |-> (hs_valid && hs_code == 2'b01)); // R2
    AST_STALLSENT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_sent) |-> (hs_valid && hs_code == 2'b11)); // R8
endmodule

bind dual_bank_out_ep dbo_ep_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_end      (rx_end),
    .rx_crc_ok   (rx_crc_ok),
    .hs_valid    (hs_valid),
    .hs_code     (hs_code),
    .rx_done_bk0 (rx_done_bk0),
    .rx_done_bk1 (rx_done_bk1),
    .stall_sent  (stall_sent),
    .next_bank   (next_bank)
);

// File: tb/dual_bank_out_ep_tb.sv
module dual_bank_out_ep_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_start = 0, rx_valid = 0, rx_end = 0, rx_crc_ok = 0;
    logic [7:0]  rx_data = 0;
    logic        fw_stall_set = 0, fw_stall_clr = 0;
    logic        fw_clr_bk0 = 0, fw_clr_bk1 = 0, fw_clr_stallsent = 0;
    logic        fw_rd_bank = 0;
    logic [5:0]  fw_rd_addr = 0;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic [7:0]  fw_rd_data;
    logic [10:0] bk0_count, bk1_count;
    logic        rx_done_bk0, rx_done_bk1, stall_sent, force_stall, next_bank, irq;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_out_ep u_dut (
        .clk(clk), .rst(rst),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .fw_stall_set(fw_stall_set), .fw_stall_clr(fw_stall_clr),
        .fw_clr_bk0(fw_clr_bk0), .fw_clr_bk1(fw_clr_bk1),
        .fw_clr_stallsent(fw_clr_stallsent),
        .fw_rd_bank(fw_rd_bank), .fw_rd_addr(fw_rd_addr), .fw_rd_data(fw_rd_data),
        .bk0_count(bk0_count), .bk1_count(bk1_count),
        .rx_done_bk0(rx_done_bk0), .rx_done_bk1(rx_done_bk1),
        .stall_sent(stall_sent), .force_stall(force_stall),
        .next_bank(next_bank), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit        m_flag [2];
    int        m_cnt  [2];
    int        m_ptr;
    bit        m_stall, m_force, m_hsv;
    int        m_code;
    byte       m_mem [2][64];
    bit        m_act, m_store, m_ovf;
    int        m_n;
    bit        t_ack, t_stl;

    always @(posedge clk) begin
        if (rst) begin
            m_flag[0] = 0; m_flag[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
            m_ptr = 0; m_stall = 0; m_force = 0; m_hsv = 0; m_code = 0;
            m_act = 0; m_store = 0; m_ovf = 0; m_n = 0;
        end else begin
            t_ack = 0; t_stl = 0; m_hsv = 0;
            if (rx_start && !m_act) begin
                m_act = 1; m_store = !m_force && !m_flag[m_ptr]; m_ovf = 0; m_n = 0;
            end else if (m_act) begin
                if (rx_end) begin
                    m_act = 0;
                    if (rx_crc_ok) begin
                        m_hsv = 1;
                        if (m_force) begin m_code = 3; t_stl = 1; end
                        else if (!m_store || m_ovf) m_code = 2;
                        else begin m_code = 1; t_ack = 1; end
                    end
                end else if (rx_valid) begin
                    if (m_n < 64) begin
                        if (m_store) m_mem[m_ptr][m_n] = rx_data;
                        m_n++;
                    end else m_ovf = 1;
                end
            end
            if (fw_clr_bk0) m_flag[0] = 0;
            if (fw_clr_bk1) m_flag[1] = 0;
            if (t_ack) begin m_flag[m_ptr] = 1; m_cnt[m_ptr] = m_n; m_ptr ^= 1; end
            if (fw_clr_stallsent) m_stall = 0;
            if (t_stl) m_stall = 1;
            if (fw_stall_set) m_force = 1;
            else if (fw_stall_clr) m_force = 0;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(hs_valid == m_hsv, "R3 hs_valid", hs_valid, m_hsv);
            if (m_hsv) chk(hs_code == m_code, "R3 hs_code", hs_code, m_code);
            chk(rx_done_bk0 == m_flag[0], "R10 flag0", rx_done_bk0, m_flag[0]);
            chk(rx_done_bk1 == m_flag[1], "R10 flag1", rx_done_bk1, m_flag[1]);
            chk(next_bank == m_ptr[0], "R2 next_bank", next_bank, m_ptr);
            chk(bk0_count == m_cnt[0], "R12 count0", bk0_count, m_cnt[0]);
            chk(bk1_count == m_cnt[1], "R12 count1", bk1_count, m_cnt[1]);
            chk(stall_sent == m_stall, "R8 stall_sent", stall_sent, m_stall);
            chk(force_stall == m_force, "R7 force_stall", force_stall, m_force);
            chk(irq == (m_flag[0] | m_flag[1] | m_stall), "R9 irq", irq,
                m_flag[0] | m_flag[1] | m_stall);
        end
    end

    // ---------------- stimulus helpers ----------------
    bit   seen_v;
    logic [1:0] seen_c;

    task automatic send_pkt(input int id, input int len, input bit crc);
        @(negedge clk); rx_start = 1;
        @(negedge clk); rx_start = 0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_data = 8'((id * 16 + i) & 255);
            @(negedge clk);
        end
        rx_valid = 0; rx_end = 1; rx_crc_ok = crc;
        @(negedge clk); rx_end = 0; rx_crc_ok = 0;
        seen_v = hs_valid; seen_c = hs_code;
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: fw_clr_bk0 = 1;
            1: fw_clr_bk1 = 1;
            2: fw_clr_stallsent = 1;
            3: fw_stall_set = 1;
            default: fw_stall_clr = 1;
        endcase
        @(negedge clk);
        fw_clr_bk0 = 0; fw_clr_bk1 = 0; fw_clr_stallsent = 0;
        fw_stall_set = 0; fw_stall_clr = 0;
    endtask

    task automatic rd_chk(input bit bank, input int addr, input int exp, input string req);
        @(negedge clk); fw_rd_bank = bank; fw_rd_addr = 6'(addr);
        @(negedge clk);
        chk(fw_rd_data == 8'(exp), req, fw_rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!rx_done_bk0 && !rx_done_bk1 && !stall_sent && !force_stall, "R1 flags", 1, 0);
        chk(!hs_valid && !irq && !next_bank, "R1 outputs", irq, 0);
        rst = 0;
        @(negedge clk);
        chk(!irq && !next_bank && !hs_valid, "R1 after release", irq, 0);

        // R2 R3: first packet into bank 0
        send_pkt(1, 5, 1);
        chk(seen_v && seen_c == 2'b01, "R3 ack A", seen_c, 1);
        chk(rx_done_bk0 && bk0_count == 5, "R3 bank0 count", bk0_count, 5);
        chk(next_bank == 1, "R2 toggle", next_bank, 1);
        rd_chk(0, 3, 19, "R11 read bank0");

        // R12 full 64-byte packet into bank 1, both flags now set (R10)
        send_pkt(2, 64, 1);
        chk(seen_v && seen_c == 2'b01, "R2 ack B", seen_c, 1);
        chk(bk1_count == 64, "R12 count 64", bk1_count, 64);
        chk(rx_done_bk0 && rx_done_bk1, "R10 both set", rx_done_bk1, 1);
        rd_chk(1, 63, (2 * 16 + 63) & 255, "R11 read bank1");

        // R4 both full -> NAK, bank 0 untouched
        send_pkt(3, 4, 1);
        chk(seen_v && seen_c == 2'b10, "R4 nak busy", seen_c, 2);
        chk(next_bank == 0 && bk0_count == 5, "R4 pointer/count kept", bk0_count, 5);
        rd_chk(0, 0, 16, "R4 bank0 not written");

        // R10 clear bank0 only, R12 zero-length accepted
        pulse(0);
        chk(!rx_done_bk0 && rx_done_bk1, "R10 clear bk0 only", rx_done_bk1, 1);
        send_pkt(4, 0, 1);
        chk(seen_v && seen_c == 2'b01, "R12 zero-length ack", seen_c, 1);
        chk(bk0_count == 0 && rx_done_bk0, "R12 zero count", bk0_count, 0);

        // R5 oversize
        pulse(1); pulse(0);
        send_pkt(5, 65, 1);
        chk(seen_v && seen_c == 2'b10, "R5 oversize nak", seen_c, 2);
        chk(!rx_done_bk1 && next_bank == 1, "R5 no flag no move", rx_done_bk1, 0);

        // R6 bad CRC
        send_pkt(6, 3, 0);
        chk(!seen_v, "R6 silent", seen_v, 0);
        chk(!rx_done_bk1 && next_bank == 1 && !irq, "R6 no flag", rx_done_bk1, 0);

        // R7 R8 R9 forced stall
        pulse(3);
        chk(force_stall, "R7 force set", force_stall, 1);
        send_pkt(7, 2, 1);
        chk(seen_v && seen_c == 2'b11, "R7 stall reply", seen_c, 3);
        chk(stall_sent && irq && !rx_done_bk1, "R8 stall_sent", stall_sent, 1);
        send_pkt(8, 0, 1);
        chk(seen_v && seen_c == 2'b11, "R7 stall again", seen_c, 3);
        pulse(4);
        chk(!force_stall, "R7 force clr", force_stall, 0);
        send_pkt(9, 2, 1);
        chk(seen_v && seen_c == 2'b01 && rx_done_bk1, "R2 ack after stall", seen_c, 1);
        chk(stall_sent, "R8 stays set", stall_sent, 1);
        pulse(2);
        chk(!stall_sent && irq, "R9 irq from flag", irq, 1);
        pulse(1); pulse(0);
        chk(!irq, "R9 irq low", irq, 0);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule